// File: doc/BRIEF.md
# CSR Access Permission Checker

This block sits beside a processor pipeline and answers one question for every control/status register access: is it allowed? The pipeline presents a 12-bit register address, its current privilege level, an operation (plain read, swap, set bits or clear bits) and a source operand. In the same cycle the block returns the register's current value and an illegal-instruction flag. A legal write commits on the next clock edge. A flagged access changes nothing.

Legality is decoded from the address bits themselves. The top two bits mark a register as read-only or writable. The next two bits give the lowest privilege level that may touch it. Only a short list of registers is implemented, so anything else is flagged. The held registers are a user scratch, a supervisor scratch, a machine scratch, a machine status word, a machine trap vector and a read-only hardware-thread identifier. The status word and the trap vector carry reserved bits that read as zero and ignore writes. They also carry fields that accept any written value but always read back a legal one.

Top module: `csr_access_guard`

## Requirements
- R1: After reset all held registers read zero. The identifier at 0xF14 reads the HART_ID parameter. The implemented addresses are 0x040, 0x140, 0x300, 0x305, 0x340 and 0xF14. Any other address is flagged illegal, and a flagged access returns zero read data.
- R2: The privilege input is coded 00 user, 01 supervisor, 11 machine. An access is flagged when the privilege input is numerically below address bits [9:8].
- R3: A writing access to an address whose bits [11:10] are 11 is flagged illegal. A plain read of such an address is not flagged.
- R4: The operation is coded 00 read, 01 swap, 10 set bits, 11 clear bits. Set or clear with a zero operand performs no write, so it is not flagged on a read-only register, and it still returns the read data.
- R5: Any access to 0x7A0 through 0x7BF is flagged illegal, at every privilege level.
- R6: Read data is the value before the access, returned in the same cycle. Swap stores the operand, set stores old OR operand, and clear stores old AND NOT operand. The new value is visible from the next clock edge.
- R7: A flagged access leaves every held register unchanged.
- R8: In the status word only bit 3 (enable), bit 7 (previous enable) and bits [12:11] (previous level) are stored. All other bits read zero and ignore writes.
- R9: The previous-level field accepts any value without a flag. A written 10 is stored as 00, and other values are stored as written.
- R10: In the trap vector, bits [31:2] store freely. The two-bit mode field stores 01 when 01 is written and 00 for any other written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 12 | Register address |
| acc_priv | input | 2 | Current privilege level |
| acc_op | input | 2 | Operation: 00 read, 01 swap, 10 set, 11 clear |
| acc_wdata | input | XLEN | Source operand |
| rdata | output | XLEN | Value of the register before the access, zero if flagged |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
On every cycle, the assertions check the flag for the debug window, privilege shortfall and read-only writes. They also check that the previous-level field never holds 10, that reserved status bits and the upper mode bit read zero, and that a flagged access leaves the machine scratch unchanged. The swap, set and clear arithmetic, the exemption for a zero operand on read-only registers, and the exact legal value chosen for each illegal write are shown only by the bench's scenarios. The bench compares those against its own register model.

// File: rtl/csr_access_guard.sv
module csr_access_guard #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HART_ID = 'h5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [11:0]     acc_addr,
  input  logic [1:0]      acc_priv,
  input  logic [1:0]      acc_op,
  input  logic [XLEN-1:0] acc_wdata,
  output logic [XLEN-1:0] rdata,
  output logic            illegal
);
  localparam logic [11:0] A_USCR = 12'h040;
  localparam logic [11:0] A_SSCR = 12'h140;
  localparam logic [11:0] A_STAT = 12'h300;
  localparam logic [11:0] A_TVEC = 12'h305;
  localparam logic [11:0] A_MSCR = 12'h340;
  localparam logic [11:0] A_HART = 12'hF14;
  localparam logic [1:0] OP_READ = 2'd0, OP_SWAP = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;
  localparam int IE_BIT = 3;
  localparam int PIE_BIT = 7;
  localparam int PP_LO = 11;

  logic [XLEN-1:0] uscr_q, sscr_q, mscratch_q;
  logic [XLEN-3:0] base_q;
  logic            mode_q, mie_q, mpie_q;
  logic [1:0]      mpp_q;

  logic [XLEN-1:0] stat_rd, cur, nv;
  logic            hit, wr_req, in_dbg, priv_ok, commit;

  always_comb begin
    stat_rd = '0;
    stat_rd[IE_BIT] = mie_q;
    stat_rd[PIE_BIT] = mpie_q;
    stat_rd[PP_LO +: 2] = mpp_q;
  end

  always_comb begin
    hit = 1'b1;
    cur = '0;
    case (acc_addr)
      A_USCR:  cur = uscr_q;
      A_SSCR:  cur = sscr_q;
      A_STAT:  cur = stat_rd;
      A_TVEC:  cur = {base_q, 1'b0, mode_q};
      A_MSCR:  cur = mscratch_q;
      A_HART:  cur = HART_ID;
      default: hit = 1'b0;
    endcase
  end

  assign wr_req  = (acc_op == OP_SWAP) || (acc_op != OP_READ && acc_wdata != '0);
  assign in_dbg  = acc_addr[11:5] == 7'h3D;
  assign priv_ok = acc_priv >= acc_addr[9:8];
  assign illegal = acc_valid && (in_dbg || !hit || !priv_ok ||
                                 (acc_addr[11:10] == 2'b11 && wr_req));
  assign rdata   = (acc_valid && !illegal) ? cur : '0;
  assign commit  = acc_valid && !illegal && wr_req;

  always_comb begin
    case (acc_op)
      OP_SWAP: nv = acc_wdata;
      OP_SET:  nv = cur | acc_wdata;
      OP_CLR:  nv = cur & ~acc_wdata;
      default: nv = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uscr_q     <= '0;
      sscr_q     <= '0;
      mscratch_q <= '0;
      base_q     <= '0;
      mode_q     <= 1'b0;
      mie_q      <= 1'b0;
      mpie_q     <= 1'b0;
      mpp_q      <= 2'b00;
    end else if (commit) begin
      case (acc_addr)
        A_USCR: uscr_q <= nv;
        A_SSCR: sscr_q <= nv;
        A_MSCR: mscratch_q <= nv;
        A_STAT: begin
          mie_q  <= nv[IE_BIT];
          mpie_q <= nv[PIE_BIT];
          mpp_q  <= (nv[PP_LO +: 2] == 2'b10) ? 2'b00 : nv[PP_LO +: 2];
        end
        A_TVEC: begin
          base_q <= nv[XLEN-1:2];
          mode_q <= nv[1:0] == 2'b01;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_access_guard_chk.sv
module csr_access_guard_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [11:0]     acc_addr,
  input logic [1:0]      acc_priv,
  input logic [1:0]      acc_op,
  input logic [XLEN-1:0] acc_wdata,
  input logic [XLEN-1:0] rdata,
  input logic            illegal,
  input logic [1:0]      mpp_q,
  input logic [XLEN-1:0] mscratch_q
);
  localparam logic [XLEN-1:0] STAT_KEEP = XLEN'(32'h0000_1888);

  // R5
  dbg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= 12'h7A0 && acc_addr <= 12'h7BF) |-> illegal);

  // R2
  low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv < acc_addr[9:8]) |-> illegal);

  // R3
  ro_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[11:10] == 2'b11 && acc_op == 2'd1) |-> illegal);

  // R7
  frozen_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(mscratch_q));

  // R9
  pp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mpp_q != 2'b10);

  // R8
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !illegal && acc_addr == 12'h300) |-> ((rdata & ~STAT_KEEP) == '0));

  // R10
  tvec_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !illegal && acc_addr == 12'h305) |-> (rdata[1] == 1'b0));

  // R1
  flagged_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (rdata == '0 && acc_wdata == acc_wdata));
endmodule

bind csr_access_guard csr_access_guard_chk #(.XLEN(XLEN)) chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_priv(acc_priv), .acc_op(acc_op), .acc_wdata(acc_wdata),
  .rdata(rdata), .illegal(illegal), .mpp_q(mpp_q), .mscratch_q(mscratch_q)
);

// File: tb/csr_access_guard_test.sv
module csr_access_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] HID = 32'h0000_0005;

  logic clk = 0, rst_n = 0, acc_valid = 0;
  logic [11:0] acc_addr = '0;
  logic [1:0] acc_priv = '0, acc_op = '0;
  logic [31:0] acc_wdata = '0, rdata;
  logic illegal;
  int checks = 0, errors = 0;

  logic [31:0] m_us = 0, m_ss = 0, m_ms = 0, m_stat = 0, m_tvec = 0;

  csr_access_guard #(.XLEN(XLEN), .HART_ID(HID)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_op(acc_op), .acc_wdata(acc_wdata),
    .rdata(rdata), .illegal(illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete (got hang, expected end)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit implemented(logic [11:0] a);
    return a == 12'h040 || a == 12'h140 || a == 12'h300 ||
           a == 12'h305 || a == 12'h340 || a == 12'hF14;
  endfunction

  function automatic bit writes(logic [1:0] op, logic [31:0] wd);
    return op == 2'd1 || (op != 2'd0 && wd != 0);
  endfunction

  function automatic bit exp_flag(logic [11:0] a, logic [1:0] p, logic [1:0] op, logic [31:0] wd);
    if (a >= 12'h7A0 && a <= 12'h7BF) return 1;
    if (!implemented(a)) return 1;
    if (p < a[9:8]) return 1;
    if (a[11:10] == 2'b11 && writes(op, wd)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h040: return m_us;
      12'h140: return m_ss;
      12'h300: return m_stat;
      12'h305: return m_tvec;
      12'h340: return m_ms;
      12'hF14: return HID;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(logic [11:0] a, logic [1:0] op, logic [31:0] wd);
    logic [31:0] o, v;
    o = model_read(a);
    v = (op == 2'd1) ? wd : (op == 2'd2) ? (o | wd) : (op == 2'd3) ? (o & ~wd) : o;
    case (a)
      12'h040: m_us = v;
      12'h140: m_ss = v;
      12'h340: m_ms = v;
      12'h300: begin
        m_stat = v & 32'h0000_1888;
        if (m_stat[12:11] == 2'b10) m_stat[12:11] = 2'b00;
      end
      12'h305: m_tvec = {v[31:2], 1'b0, v[1:0] == 2'b01};
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(string tag, logic [11:0] a, logic [1:0] p, logic [1:0] op, logic [31:0] wd);
    bit f;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_priv = p; acc_op = op; acc_wdata = wd;
    #(CLK_PERIOD/4);
    f = exp_flag(a, p, op, wd);
    check({tag, " flag"}, {31'b0, illegal}, {31'b0, f});
    check({tag, " rdata"}, rdata, f ? 32'h0 : model_read(a));
    @(posedge clk);
    if (!f && writes(op, wd)) model_write(a, op, wd);
    #1 acc_valid = 0;
  endtask

  initial begin
    logic [11:0] pool [10];
    pool = '{12'h040, 12'h140, 12'h300, 12'h305, 12'h340, 12'hF14,
             12'h7A3, 12'h7B1, 12'h200, 12'hC00};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset values and identifier
    access("R1 reset status", 12'h300, 2'b11, 2'd0, 0);
    access("R1 reset mscratch", 12'h340, 2'b11, 2'd0, 0);
    access("R1 hart id", 12'hF14, 2'b11, 2'd0, 0);
    access("R1 unimplemented", 12'h341, 2'b11, 2'd0, 0);
    // R6 swap then read back, set and clear
    access("R6 swap", 12'h340, 2'b11, 2'd1, 32'hA5A5_0F0F);
    access("R6 set", 12'h340, 2'b11, 2'd2, 32'h0000_F000);
    access("R6 clear", 12'h340, 2'b11, 2'd3, 32'hA000_0003);
    access("R6 readback", 12'h340, 2'b11, 2'd0, 0);
    // R2 user touching supervisor and machine registers
    access("R2 user on sscratch", 12'h140, 2'b00, 2'd1, 32'h1);
    access("R2 super on mscratch", 12'h340, 2'b01, 2'd0, 0);
    access("R2 super on sscratch", 12'h140, 2'b01, 2'd1, 32'h77);
    // R7 state unchanged after flagged write
    access("R7 mscratch kept", 12'h340, 2'b11, 2'd0, 0);
    // R3 read-only write, R4 zero-operand set/clear
    access("R3 swap on id", 12'hF14, 2'b11, 2'd1, 0);
    access("R4 set zero on id", 12'hF14, 2'b11, 2'd2, 0);
    access("R4 clear zero on id", 12'hF14, 2'b11, 2'd3, 0);
    access("R3 set nonzero on id", 12'hF14, 2'b11, 2'd2, 32'h4);
    // R5 debug window
    access("R5 debug low", 12'h7A0, 2'b11, 2'd0, 0);
    access("R5 debug high", 12'h7BF, 2'b11, 2'd0, 0);
    // R8 reserved bits, R9 previous-level mapping
    access("R8 status all ones", 12'h300, 2'b11, 2'd1, 32'hFFFF_FFFF);
    access("R8 status readback", 12'h300, 2'b11, 2'd0, 0);
    access("R9 pp write 10", 12'h300, 2'b11, 2'd1, 32'h0000_1000);
    access("R9 pp readback", 12'h300, 2'b11, 2'd0, 0);
    access("R9 pp write 01", 12'h300, 2'b11, 2'd1, 32'h0000_0800);
    access("R9 pp readback 01", 12'h300, 2'b11, 2'd0, 0);
    // R10 trap vector mode
    access("R10 mode 3", 12'h305, 2'b11, 2'd1, 32'h8000_0103);
    access("R10 readback", 12'h305, 2'b11, 2'd0, 0);
    access("R10 mode 1", 12'h305, 2'b11, 2'd1, 32'h0000_0041);
    access("R10 readback 1", 12'h305, 2'b11, 2'd0, 0);
    access("R10 mode 2", 12'h305, 2'b11, 2'd2, 32'h0000_0002);
    access("R10 readback 2", 12'h305, 2'b11, 2'd0, 0);
    // random mix covering R1 to R10
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [1:0] p, op;
      logic [31:0] wd;
      a = ($urandom % 8 == 0) ? 12'($urandom) : pool[$urandom % 10];
      p = ($urandom % 3 == 2) ? 2'b11 : 2'($urandom % 2);
      op = 2'($urandom);
      wd = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      access("R6 random", a, p, op, wd);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule